// File: doc/BRIEF.md
# Byte-Framed Serial Command Slave

This block is the slave end of a bit-serial host port with one data line shared in both directions. The host frames every byte with its own chip-select low window. The first byte of a transaction is a command. A fixed internal table maps the command code to a byte count and a direction. The bytes that follow are either written into a register file through a simple address/data/strobe port, or read from that register file and shifted back to the host. The block drives the data line only while it sends read data. Otherwise the line stays released.

The serial clock, chip select and data input are asynchronous to the system clock. The block brings them in through synchronizers and finds their edges by oversampling, so the serial clock must be several times slower than the system clock. The serial clock idles low between bytes, and it may stop or keep toggling while chip select is high.

Any burst of too many clock edges inside one window is treated as a host request for a reset. When that happens the block drops the current transaction, releases the data line and pulses a reset output.

Top module: `cmd_serial_slave`

## Requirements
- R1: Bytes are 8 bits, most significant bit first, in both directions. The input bit is sampled on each rising serial-clock edge while chip select is low. A byte is accepted when chip select rises after at least 8 rising edges.
- R2: Command table: 0x02 writes 1 byte at base 0x00, 0x03 reads 1 byte at 0x00, 0x18 writes 2 bytes at 0x10, 0x19 reads 2 bytes at 0x10, 0x40 writes 15 bytes at 0x20, 0x41 reads 15 bytes at 0x20, and 0x50 is a known zero-length command. After a zero-length command the next byte is again a command.
- R3: Each data byte of a write gives exactly one single-cycle reg_we pulse, with reg_wdata equal to the byte. reg_addr starts at the command base and increases by one for each byte.
- R4: In each read-data window the slave sends reg_rdata at the current address. The MSB is driven from the falling edge of chip select, and each falling serial-clock edge moves to the next bit. After the command's full count (two bytes for 0x19), the next byte is a command.
- R5: Bytes the host sends during read-data windows are not decoded as commands and cause no writes.
- R6: A 16th rising serial-clock edge inside one chip-select window produces a one-cycle dev_reset pulse. It abandons the transaction and releases ser_oe at once. The rest of that window is discarded.
- R7: A window that ends with fewer than 8 rising edges is discarded. The transaction state is unchanged: the same read byte is sent again, and the write address does not move.
- R8: ser_oe is high only inside read-data windows. It is low in command windows and in write-data windows.
- R9: An unrecognised command code causes no write, and the next byte is decoded as a command.
- R10: Serial-clock edges while chip select is high have no effect. The transaction in progress continues afterwards.
- R11: After rst_n is released, ser_oe, reg_we and dev_reset are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_csn | input | 1 | Active-low byte-framing chip select |
| ser_din | input | 1 | Data line as seen at the pad input |
| ser_dout | output | 1 | Data bit driven toward the pad |
| ser_oe | output | 1 | Pad output enable for the data line |
| reg_addr | output | ADDR_W | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | Register file write strobe |
| reg_rdata | input | 8 | Register file read data (combinational on reg_addr) |
| dev_reset | output | 1 | One-cycle pulse on an overclocked window |

## Verification
The hardest states to reach are a window that carries too many edges and a window that is cut short while a transaction is only part done. Both must leave the sequencer in a defined state. The host model's byte task takes an edge count, so the stimulus can cut a window off, or overrun it, in the middle of a write and in the middle of a read. The bench then checks that the data line was released before chip select rose. It also sends a follow-up command and data byte, which show through the write scoreboard and the returned read bytes whether the transaction was kept or dropped. Clock toggling with chip select high is placed between two data bytes of a write, so any leaked edge would corrupt the second write.

// File: rtl/cmdslv_pkg.sv
package cmdslv_pkg;

   localparam int BYTE_W = 8;
   localparam int LEN_W  = 4;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef struct packed {
      logic             known;
      logic             rd;
      logic [LEN_W-1:0] len;
      byte_t            base;
   } cmd_info_t;

   typedef enum logic [1:0] {
      SEQ_CMD   = 2'd0,
      SEQ_WRITE = 2'd1,
      SEQ_READ  = 2'd2
   } seq_state_t;

   function automatic cmd_info_t cmd_lookup(input byte_t code);
      cmd_info_t r;
      r = '{known: 1'b0, rd: 1'b0, len: '0, base: '0};
      case (code)
         8'h02: r = '{known: 1'b1, rd: 1'b0, len: 4'd1,  base: 8'h00};
         8'h03: r = '{known: 1'b1, rd: 1'b1, len: 4'd1,  base: 8'h00};
         8'h18: r = '{known: 1'b1, rd: 1'b0, len: 4'd2,  base: 8'h10};
         8'h19: r = '{known: 1'b1, rd: 1'b1, len: 4'd2,  base: 8'h10};
         8'h40: r = '{known: 1'b1, rd: 1'b0, len: 4'd15, base: 8'h20};
         8'h41: r = '{known: 1'b1, rd: 1'b1, len: 4'd15, base: 8'h20};
         8'h50: r = '{known: 1'b1, rd: 1'b0, len: 4'd0,  base: 8'h00};
         default: ;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cmdslv_sync.sv
module cmdslv_sync #(
   parameter int             W       = 3,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_width
      $error("cmdslv_sync: W must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("cmdslv_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= RST_VAL;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st[0] <= RST_VAL;
         else        st[0] <= d;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= RST_VAL;
            else        st[i] <= st[i-1];
         end
      end
      assign q = st[STAGES-1];
   end

endmodule

// File: rtl/cmdslv_framer.sv
module cmdslv_framer
   import cmdslv_pkg::*;
#(
   parameter int RESET_EDGES = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sclk_s,
   input  logic  csn_s,
   input  logic  din_s,
   input  logic  tx_en,
   input  byte_t tx_byte,
   output logic  byte_ok,
   output byte_t rx_byte,
   output logic  ovr,
   output logic  dio_out,
   output logic  dio_oe
);

   localparam int CNT_W = $clog2(RESET_EDGES + 1);

   if (RESET_EDGES <= BYTE_W) begin : g_bad_edges
      $error("cmdslv_framer: RESET_EDGES must exceed the byte width");
   end

   logic             sclk_d, csn_d;
   logic             rise, fall, cs_fall, cs_rise, in_win;
   logic [CNT_W-1:0] cnt;
   logic             poisoned;
   byte_t            rx_sh, tx_sh;

   assign rise    =  sclk_s & ~sclk_d;
   assign fall    = ~sclk_s &  sclk_d;
   assign cs_fall = ~csn_s  &  csn_d;
   assign cs_rise =  csn_s  & ~csn_d;
   assign in_win  = ~csn_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         csn_d    <= 1'b1;
         cnt      <= '0;
         poisoned <= 1'b0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         byte_ok  <= 1'b0;
         ovr      <= 1'b0;
         dio_oe   <= 1'b0;
      end else begin
         sclk_d  <= sclk_s;
         csn_d   <= csn_s;
         byte_ok <= 1'b0;
         ovr     <= 1'b0;
         if (cs_fall) begin
            cnt      <= '0;
            poisoned <= 1'b0;
            tx_sh    <= tx_byte;
            dio_oe   <= tx_en;
         end else if (cs_rise) begin
            byte_ok <= ~poisoned && (cnt >= CNT_W'(BYTE_W));
            dio_oe  <= 1'b0;
         end else if (in_win && !poisoned) begin
            if (rise) begin
               rx_sh <= {rx_sh[BYTE_W-2:0], din_s};
               cnt   <= cnt + 1'b1;
               if (cnt == CNT_W'(RESET_EDGES - 1)) begin
                  ovr      <= 1'b1;
                  poisoned <= 1'b1;
                  dio_oe   <= 1'b0;
               end
            end else if (fall) begin
               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign rx_byte = rx_sh;
   assign dio_out = tx_sh[BYTE_W-1];

   assert_byte_at_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ok |-> $past(csn_s));
   assert_ovr_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |-> $past(~csn_s));
   assert_ovr_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |-> !dio_oe);
   assert_oe_starts_at_cs_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dio_oe) |-> $past(cs_fall));

endmodule

// File: rtl/cmdslv_seq.sv
module cmdslv_seq
   import cmdslv_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_ok,
   input  byte_t             rx_byte,
   input  logic              ovr,
   output logic              rd_active,
   output logic [ADDR_W-1:0] reg_addr,
   output byte_t             reg_wdata,
   output logic              reg_we,
   output logic              dev_reset
);

   seq_state_t       state;
   logic [LEN_W-1:0] remain;
   logic [ADDR_W-1:0] ptr;
   cmd_info_t        info;

   always_comb info = cmd_lookup(rx_byte);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_CMD;
         remain    <= '0;
         ptr       <= '0;
         reg_we    <= 1'b0;
         reg_wdata <= '0;
         dev_reset <= 1'b0;
      end else begin
         reg_we    <= 1'b0;
         dev_reset <= 1'b0;
         if (reg_we) ptr <= ptr + 1'b1;
         if (ovr) begin
            state     <= SEQ_CMD;
            remain    <= '0;
            dev_reset <= 1'b1;
         end else if (byte_ok) begin
            case (state)
               SEQ_CMD: begin
                  if (info.known && info.len != '0) begin
                     state  <= info.rd ? SEQ_READ : SEQ_WRITE;
                     remain <= info.len;
                     ptr    <= ADDR_W'(info.base);
                  end
               end
               SEQ_WRITE: begin
                  reg_we    <= 1'b1;
                  reg_wdata <= rx_byte;
                  remain    <= remain - 1'b1;
                  if (remain == LEN_W'(1)) state <= SEQ_CMD;
               end
               SEQ_READ: begin
                  ptr    <= ptr + 1'b1;
                  remain <= remain - 1'b1;
                  if (remain == LEN_W'(1)) state <= SEQ_CMD;
               end
               default: state <= SEQ_CMD;
            endcase
         end
      end
   end

   assign rd_active = (state == SEQ_READ);
   assign reg_addr  = ptr;

   assert_busy_has_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state != SEQ_CMD) |-> (remain != '0));
   assert_we_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $past(state == SEQ_WRITE));
   assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);
   assert_ovr_abandons_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> (state == SEQ_CMD) && dev_reset);

endmodule

// File: rtl/cmd_serial_slave.sv
module cmd_serial_slave
   import cmdslv_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter int RESET_EDGES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_csn,
   input  logic              ser_din,
   output logic              ser_dout,
   output logic              ser_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [7:0]        reg_wdata,
   output logic              reg_we,
   input  logic [7:0]        reg_rdata,
   output logic              dev_reset
);

   if (ADDR_W < 6) begin : g_bad_addr
      $error("cmd_serial_slave: ADDR_W must cover the command bases (>= 6)");
   end

   logic [2:0] sync_q;
   logic       byte_ok, ovr, rd_active;
   byte_t      rx_byte;

   cmdslv_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_clk, ser_csn, ser_din}),
      .q     (sync_q)
   );

   cmdslv_framer #(.RESET_EDGES(RESET_EDGES)) u_framer (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (sync_q[2]),
      .csn_s   (sync_q[1]),
      .din_s   (sync_q[0]),
      .tx_en   (rd_active),
      .tx_byte (reg_rdata),
      .byte_ok (byte_ok),
      .rx_byte (rx_byte),
      .ovr     (ovr),
      .dio_out (ser_dout),
      .dio_oe  (ser_oe)
   );

   cmdslv_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_ok   (byte_ok),
      .rx_byte   (rx_byte),
      .ovr       (ovr),
      .rd_active (rd_active),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .dev_reset (dev_reset)
   );

   assert_oe_read_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ser_oe |-> rd_active);
   assert_no_write_while_driving_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ser_oe |-> !reg_we);

endmodule

// File: tb/tb_cmd_serial_slave.sv
`timescale 1ns/1ps
module tb_cmd_serial_slave;

   localparam int HP = 32;

   logic       clk = 1'b0;
   logic       rst_n, ser_clk, ser_csn, host_bit;
   logic       ser_din, ser_dout, ser_oe, reg_we, dev_reset;
   logic [5:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic [7:0] mem [64];
   logic [7:0] shadow [64];

   typedef struct { logic [5:0] a; logic [7:0] d; } wr_t;
   wr_t expq [$];
   int  checks = 0, fails = 0, rst_seen = 0;

   always #2 clk = ~clk;

   assign ser_din   = ser_oe ? ser_dout : host_bit;
   assign reg_rdata = mem[reg_addr];

   always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

   cmd_serial_slave dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_csn(ser_csn),
      .ser_din(ser_din), .ser_dout(ser_dout), .ser_oe(ser_oe),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
      .reg_rdata(reg_rdata), .dev_reset(dev_reset)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected writes from the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_we) begin
            if (expq.size() == 0) chk(1'b0, "R3 unexpected write", int'(reg_addr), -1);
            else begin
               wr_t e;
               e = expq.pop_front();
               chk(reg_addr == e.a, "R3 write address", int'(reg_addr), int'(e.a));
               chk(reg_wdata == e.d, "R1 write data", int'(reg_wdata), int'(e.d));
            end
         end
         if (dev_reset) rst_seen++;
      end
   end

   task automatic expect_wr(input logic [5:0] a, input logic [7:0] d);
      wr_t e;
      e.a = a; e.d = d;
      expq.push_back(e);
      shadow[a] = d;
   endtask

   task automatic xfer(input logic [7:0] tx, input int n, output logic [7:0] rx,
                       output bit oe_any, output bit oe_end);
      rx = 8'h00; oe_any = 1'b0;
      ser_csn = 1'b0;
      #HP;
      for (int i = 0; i < n; i++) begin
         host_bit = (i < 8) ? tx[7-i] : 1'b0;
         if (ser_oe) oe_any = 1'b1;
         if (i < 8) rx[7-i] = ser_dout;
         #HP ser_clk = 1'b1;
         #HP ser_clk = 1'b0;
         #HP;
      end
      oe_end = ser_oe;
      ser_csn = 1'b1;
      host_bit = 1'b0;
      #(4*HP);
   endtask

   task automatic send(input logic [7:0] b);
      logic [7:0] r; bit a, e;
      xfer(b, 8, r, a, e);
   endtask

   task automatic read_chk(input logic [5:0] a, input string req);
      logic [7:0] r; bit oa, oe;
      xfer(8'h00, 8, r, oa, oe);
      chk(r == shadow[a], req, int'(r), int'(shadow[a]));
      chk(oa == 1'b1, "R8 oe in read window", int'(oa), 1);
   endtask

   task automatic drain(input string req);
      #(4*HP);
      chk(expq.size() == 0, req, expq.size(), 0);
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] r; bit oa, oe; int rs;
      rst_n = 1'b0; ser_clk = 1'b0; ser_csn = 1'b1; host_bit = 1'b0;
      for (int i = 0; i < 64; i++) begin
         mem[i] = 8'(i * 37 + 11);
         shadow[i] = mem[i];
      end
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(ser_oe == 1'b0, "R11 oe at reset", int'(ser_oe), 0);
      chk(reg_we == 1'b0, "R11 we at reset", int'(reg_we), 0);
      chk(dev_reset == 1'b0, "R11 dev_reset at reset", int'(dev_reset), 0);
      rst_n = 1'b1;
      #(10*HP);

      // R9: unknown code, then a real command
      send(8'h77);
      send(8'h02); expect_wr(6'h00, 8'h5A); send(8'h5A);
      drain("R9 unknown code then command");

      // R3: two-byte write
      send(8'h18); expect_wr(6'h10, 8'h81); send(8'h81);
      expect_wr(6'h11, 8'h3C); send(8'h3C);
      drain("R3 two-byte write");

      // R4 / R8: read 0x19, command window releases the line
      xfer(8'h19, 8, r, oa, oe);
      chk(oa == 1'b0, "R8 oe in command window", int'(oa), 0);
      read_chk(6'h10, "R4 read byte 0");
      read_chk(6'h11, "R4 read byte 1");
      xfer(8'h03, 8, r, oa, oe);
      chk(oa == 1'b0, "R4 back to command after two bytes", int'(oa), 0);
      read_chk(6'h00, "R4 single read");

      // R5: host sends a write command code inside a read window
      send(8'h19);
      xfer(8'h02, 8, r, oa, oe);
      chk(r == shadow[6'h10], "R5 read byte unaffected", int'(r), int'(shadow[6'h10]));
      read_chk(6'h11, "R5 second read byte");
      send(8'h03); read_chk(6'h00, "R5 command after read");
      drain("R5 no writes during read");

      // R7: short windows
      send(8'h02);
      xfer(8'hEE, 5, r, oa, oe);
      expect_wr(6'h00, 8'hC3); send(8'hC3);
      drain("R7 short write byte discarded");
      send(8'h19);
      xfer(8'h00, 4, r, oa, oe);
      read_chk(6'h10, "R7 read byte resent");
      read_chk(6'h11, "R7 read continues");

      // R10: clock toggles with chip select high mid-write
      rs = rst_seen;
      send(8'h18); expect_wr(6'h10, 8'h96); send(8'h96);
      for (int i = 0; i < 20; i++) begin
         #HP ser_clk = 1'b1;
         #HP ser_clk = 1'b0;
      end
      #(4*HP);
      expect_wr(6'h11, 8'h69); send(8'h69);
      drain("R10 write survives idle clocks");
      chk(rst_seen == rs, "R10 no reset from idle clocks", rst_seen, rs);

      // R6: overclock during a write
      rs = rst_seen;
      send(8'h18); expect_wr(6'h10, 8'h12); send(8'h12);
      xfer(8'hFF, 16, r, oa, oe);
      chk(rst_seen == rs + 1, "R6 reset pulse", rst_seen, rs + 1);
      send(8'h02); expect_wr(6'h00, 8'h44); send(8'h44);
      drain("R6 transaction abandoned");

      // R6: overclock during a read releases the line
      send(8'h19);
      xfer(8'h00, 16, r, oa, oe);
      chk(oe == 1'b0, "R6 oe released after overclock", int'(oe), 0);
      chk(rst_seen == rs + 2, "R6 second reset pulse", rst_seen, rs + 2);
      send(8'h03); read_chk(6'h00, "R6 command after reset");

      // R2: longest write and read, then zero-length command
      send(8'h40);
      for (int i = 0; i < 15; i++) begin
         expect_wr(6'(6'h20 + i), 8'(8'hA0 + i * 3)); send(8'(8'hA0 + i * 3));
      end
      drain("R2 fifteen-byte write");
      send(8'h41);
      for (int i = 0; i < 15; i++) read_chk(6'(6'h20 + i), "R2 fifteen-byte read");
      send(8'h50);
      send(8'h03); read_chk(6'h00, "R2 zero-length command");
      drain("R2 final");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule